// File: doc/BRIEF.md
# Double-Banked Wavetable Playback Channel

This block is one voice of a sound unit. It plays back a user-defined waveform made of 4-bit samples. The samples sit in a wave memory that is split into two banks of 32 samples each. Software fills that memory through a 16-bit write port. A write always lands in the bank that is not currently playing, so one pattern can be loaded while the other one sounds. The play-bank select can be flipped at any time and the new bank is heard without restarting the voice. A chain-mode bit joins the two banks into a single 64-sample loop.

Playback is armed by the enable bit together with a trigger. The trigger restarts the sample index at zero in the playing bank. The sample clock is derived from an 11-bit frequency code: one sample lasts `(2048 - freq) * CLK_DIV` clock cycles. An optional timed mode stops the voice after a programmable number of external length ticks; each tick is 1/256 s in the target system. The current sample is scaled by a 3-bit level code and driven out together with an activity flag that feeds the mixer.

Top module: `wavetable_channel`

## Requirements
- R1: After synchronous reset, `active` is 0, `sample_out` is 0, every word of both banks holds zero and the sample index is 0.
- R2: A write with `wr_en` stores `wr_data` at halfword `wr_addr` of bank `~play_bank` and leaves bank `play_bank` unchanged. Bits 7:0 of halfword `a` form byte `2a` of the bank and bits 15:8 form byte `2a+1`.
- R3: Sample `i` of a bank is taken from byte `i>>1`: the high nibble when `i` is even, the low nibble when `i` is odd. A halfword 0x4567 at address 0 therefore plays 6, 7, 4, 5.
- R4: While active, the sample index advances by one every `(2048 - freq) * CLK_DIV` clock cycles, counted from the trigger edge. The frequency is sampled at each reload.
- R5: With `chain_mode` = 0 the index wraps from 31 to 0 inside bank `play_bank`. With `chain_mode` = 1 it wraps from 63 to 0: indices 0 to 31 read bank `play_bank` and indices 32 to 63 read the other bank.
- R6: Changing `play_bank` while active changes the bank that `sample_out` reads in the same cycle. It does not restart the index and does not clear `active`.
- R7: `sample_out` is the sample `s` scaled by the level code: 000 gives 0, 001 gives `s`, 010 gives `s>>1`, 011 gives `s>>2`, and any code with bit 2 set gives `(s>>1)+(s>>2)`.
- R8: A trigger with `out_en` = 1 sets `active` at the next edge. `out_en` = 0 clears `active` at the next edge and blocks any trigger. `sample_out` is 0 while `active` is 0.
- R9: A trigger loads the length count from `len_val`. When `timed` = 1, each `len_tick` seen while active decrements the count, and a tick that finds the count at 1 or 0 clears `active`. When `timed` = 0, ticks have no effect.
- R10: A trigger while already active restarts the index at 0, reloads the sample timer and reloads the length count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Wave memory write strobe |
| wr_addr | input | 3 | Halfword address inside the non-playing bank |
| wr_data | input | 16 | Four packed samples |
| chain_mode | input | 1 | 1 joins both banks into a 64-sample loop |
| play_bank | input | 1 | Bank that plays; writes go to the other one |
| out_en | input | 1 | Voice enable |
| freq | input | 11 | Sample-rate code |
| len_val | input | 8 | Length in ticks for timed mode |
| timed | input | 1 | 1 stops the voice when the length expires |
| level | input | 3 | Output level code |
| trigger | input | 1 | Restart strobe |
| len_tick | input | 1 | Length time-base strobe |
| sample_out | output | 4 | Scaled sample |
| active | output | 1 | Voice playing |

## Verification
The properties assume that `trigger` and `len_tick` are single-cycle strobes. They also assume that the level and enable inputs are settled from the edge before the cycle being judged. The bench meets both assumptions by changing inputs only just after a rising edge and by pulsing each strobe for exactly one cycle. In the random phase, triggers are issued with enable mostly high. Frequency codes are drawn near the top of the range so that index wrap, chain crossing and bank flips all occur within a short run.

// File: rtl/wt_pkg.sv
package wt_pkg;
    localparam int BANK_SAMPLES = 32;
    localparam int NUM_BANKS    = 2;
    localparam int HW_PER_BANK  = BANK_SAMPLES / 4;
    localparam int HW_AW        = $clog2(HW_PER_BANK);
    localparam int IDX_W        = $clog2(BANK_SAMPLES * NUM_BANKS);
    localparam int FREQ_W       = 11;
    localparam int LEN_W        = 8;
    localparam int FREQ_SPAN    = 1 << FREQ_W;

    typedef enum logic [2:0] {
        LVL_MUTE    = 3'b000,
        LVL_FULL    = 3'b001,
        LVL_HALF    = 3'b010,
        LVL_QUARTER = 3'b011
    } level_e;

    typedef struct packed {
        logic             bank;
        logic [HW_AW-1:0] hw;
        logic [1:0]       pos;
    } rd_sel_t;

    // Even sample of a byte is its high nibble; bytes ascend with address.
    function automatic logic [3:0] pick_nibble(input logic [15:0] hw, input logic [1:0] pos);
        logic [7:0] byte_v;
        byte_v = pos[1] ? hw[15:8] : hw[7:0];
        return pos[0] ? byte_v[3:0] : byte_v[7:4];
    endfunction

    function automatic logic [3:0] scale_level(input logic [3:0] s, input logic [2:0] code);
        logic [3:0] r;
        if (code[2]) r = (s >> 1) + (s >> 2);
        else begin
            case (level_e'(code))
                LVL_FULL:    r = s;
                LVL_HALF:    r = s >> 1;
                LVL_QUARTER: r = s >> 2;
                default:     r = 4'd0;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/wt_ram.sv
module wt_ram
    import wt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [HW_AW-1:0] wr_addr,
    input  logic [15:0]      wr_data,
    input  logic             rd_bank,
    input  logic [HW_AW-1:0] rd_addr,
    output logic [15:0]      rd_data
);
    logic [15:0] bank_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [15:0] mem [HW_PER_BANK];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < HW_PER_BANK; i++) mem[i] <= '0;
            end else if (wr_en && (int'(wr_bank) == b)) begin
                mem[wr_addr] <= wr_data;
            end
        end
        assign bank_q[b] = mem[rd_addr];
    end

    assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/wt_sequencer.sv
module wt_sequencer
    import wt_pkg::*;
#(
    parameter int CLK_DIV = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_en,
    input  logic              trigger,
    input  logic              chain_mode,
    input  logic [FREQ_W-1:0] freq,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              timed,
    input  logic              len_tick,
    output logic              active,
    output logic [IDX_W-1:0]  idx
);
    localparam int TMR_W = $clog2(FREQ_SPAN * CLK_DIV + 1);

    logic [TMR_W-1:0] tmr;
    logic [LEN_W-1:0] len_cnt;
    logic [31:0]      span;
    logic [TMR_W-1:0] reload;
    logic [IDX_W-1:0] idx_next;

    assign span   = (32'(FREQ_SPAN) - 32'(freq)) * 32'(CLK_DIV);
    assign reload = TMR_W'(span - 32'd1);

    always_comb begin
        if (chain_mode) idx_next = idx + 1'b1;
        else            idx_next = {1'b0, idx[IDX_W-2:0] + 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            idx     <= '0;
            tmr     <= '0;
            len_cnt <= '0;
        end else if (!out_en) begin
            active <= 1'b0;
        end else if (trigger) begin
            active  <= 1'b1;
            idx     <= '0;
            tmr     <= reload;
            len_cnt <= len_val;
        end else if (active) begin
            if (tmr == '0) begin
                tmr <= reload;
                idx <= idx_next;
            end else begin
                tmr <= tmr - 1'b1;
            end
            if (timed && len_tick) begin
                if (len_cnt <= LEN_W'(1)) begin
                    active  <= 1'b0;
                    len_cnt <= '0;
                end else begin
                    len_cnt <= len_cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wavetable_channel.sv
module wavetable_channel
    import wt_pkg::*;
#(
    parameter int CLK_DIV = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic        chain_mode,
    input  logic        play_bank,
    input  logic        out_en,
    input  logic [10:0] freq,
    input  logic [7:0]  len_val,
    input  logic        timed,
    input  logic [2:0]  level,
    input  logic        trigger,
    input  logic        len_tick,
    output logic [3:0]  sample_out,
    output logic        active
);
    logic [IDX_W-1:0] idx;
    logic [15:0]      rd_data;
    rd_sel_t          sel;

    wt_sequencer #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk(clk), .rst(rst), .out_en(out_en), .trigger(trigger),
        .chain_mode(chain_mode), .freq(freq), .len_val(len_val),
        .timed(timed), .len_tick(len_tick), .active(active), .idx(idx)
    );

    always_comb begin
        sel.bank = play_bank ^ (chain_mode & idx[IDX_W-1]);
        sel.hw   = idx[HW_AW+1:2];
        sel.pos  = idx[1:0];
    end

    wt_ram u_ram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(~play_bank),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_bank(sel.bank), .rd_addr(sel.hw), .rd_data(rd_data)
    );

    assign sample_out = active ? scale_level(pick_nibble(rd_data, sel.pos), level) : 4'd0;
endmodule

// File: rtl/wt_channel_chk.sv
module wt_channel_chk (
    input logic       clk,
    input logic       rst,
    input logic       out_en,
    input logic       trigger,
    input logic       timed,
    input logic [2:0] level,
    input logic [3:0] sample_out,
    input logic       active
);
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !active);

    a_r8_start: assert property (@(posedge clk) disable iff (rst)
        (trigger && out_en) |=> active);

    a_r8_disable: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> !active);

    a_r8_silent_idle: assert property (@(posedge clk) disable iff (rst)
        !active |-> sample_out == 4'd0);

    a_r7_mute: assert property (@(posedge clk) disable iff (rst)
        level == 3'b000 |-> sample_out == 4'd0);

    a_r7_quarter_range: assert property (@(posedge clk) disable iff (rst)
        level == 3'b011 |-> sample_out <= 4'd3);

    a_r9_untimed_holds: assert property (@(posedge clk) disable iff (rst)
        (active && out_en && !timed) |=> active);
endmodule

bind wavetable_channel wt_channel_chk u_chk (
    .clk(clk), .rst(rst), .out_en(out_en), .trigger(trigger), .timed(timed),
    .level(level), .sample_out(sample_out), .active(active)
);

// File: tb/wavetable_channel_tb.sv
`timescale 1ns/1ps
module wavetable_channel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic        chain_mode = 0, play_bank = 0, out_en = 0, timed = 0;
    logic [10:0] freq = 0;
    logic [7:0]  len_val = 0;
    logic [2:0]  level = 0;
    logic        trigger = 0, len_tick = 0;
    logic [3:0]  sample_out;
    logic        active;

    int nvec = 0, nfail = 0, cycles = 0;
    bit model_chk = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    wavetable_channel u_dut (.*);

    // Reference model built from the requirements
    logic [15:0] m_ram [2][8];
    logic        m_act;
    logic [5:0]  m_idx;
    logic [11:0] m_tmr;
    logic [7:0]  m_len;

    function automatic logic [11:0] m_reload(input logic [10:0] f);
        return 12'(12'd2048 - {1'b0, f} - 12'd1);
    endfunction

    function automatic logic [3:0] f_scale(input logic [3:0] s, input logic [2:0] c);
        if (c[2]) return 4'((s >> 1) + (s >> 2));
        case (c)
            3'd1: return s;
            3'd2: return s >> 1;
            3'd3: return s >> 2;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [3:0] f_expect();
        logic       b;
        logic [4:0] i;
        logic [7:0] by;
        if (!m_act) return 4'd0;
        b  = play_bank ^ (chain_mode & m_idx[5]);
        i  = m_idx[4:0];
        by = i[1] ? m_ram[b][i[4:2]][15:8] : m_ram[b][i[4:2]][7:0];
        return f_scale(i[0] ? by[3:0] : by[7:4], level);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act <= 0; m_idx <= 0; m_tmr <= 0; m_len <= 0;
            for (int b = 0; b < 2; b++) for (int a = 0; a < 8; a++) m_ram[b][a] <= 16'h0;
        end else begin
            if (wr_en) m_ram[~play_bank][wr_addr] <= wr_data;
            if (!out_en) m_act <= 0;
            else if (trigger) begin
                m_act <= 1; m_idx <= 0; m_tmr <= m_reload(freq); m_len <= len_val;
            end else if (m_act) begin
                if (m_tmr == 0) begin
                    m_tmr <= m_reload(freq);
                    m_idx <= chain_mode ? 6'(m_idx + 1) : {1'b0, 5'(m_idx[4:0] + 1)};
                end else m_tmr <= m_tmr - 1;
                if (timed && len_tick) begin
                    if (m_len <= 1) begin m_act <= 0; m_len <= 0; end
                    else m_len <= m_len - 1;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_chk && !rst) begin
            chk("R2 R3 R4 R5 R6 R10 sample", int'(sample_out), int'(f_expect()));
            chk("R8 R9 active", int'(active), int'(m_act));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic step(); @(posedge clk); #1; endtask
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; step(); wr_en = 0;
    endtask
    task automatic trig(); trigger = 1; step(); trigger = 0; endtask
    task automatic tick(); len_tick = 1; step(); len_tick = 0; endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        step(); step(); rst = 0; step();
        // R1: reset state
        @(negedge clk);
        chk("R1 active", int'(active), 0);
        chk("R1 sample", int'(sample_out), 0);
        step();
        model_chk = 1;
        // R1 banks zero: play bank 0 at full level
        out_en = 1; level = 3'd1; freq = 11'd2047; trig();
        @(negedge clk); chk("R1 zero ram", int'(sample_out), 0);
        step();
        // R2/R3: write bank 0 (play bank 1), then play bank 0
        play_bank = 1; wr(3'd0, 16'h4567); wr(3'd1, 16'h0123);
        play_bank = 0; trigger = 1; @(posedge clk); #1 trigger = 0;
        begin
            int seq [8] = '{6,7,4,5,2,3,0,1};
            for (int k = 0; k < 8; k++) begin
                @(negedge clk); chk("R3 nibble order", int'(sample_out), seq[k]);
            end
        end
        step();
        // R2: write while bank 0 plays must not alter it; R6: flip without trigger
        wr(3'd0, 16'hFFFF);
        freq = 11'd0; trig();
        @(negedge clk); chk("R2 playing bank untouched", int'(sample_out), 6);
        step(); play_bank = 1;
        @(negedge clk); chk("R6 bank flip live", int'(sample_out), 15);
        chk("R6 still active", int'(active), 1);
        // R7: level map on s=15
        begin
            int lv [6] = '{0,15,7,3,10,10};
            logic [2:0] cd [6] = '{3'd0,3'd1,3'd2,3'd3,3'd4,3'd7};
            for (int k = 0; k < 6; k++) begin
                step(); level = cd[k];
                @(negedge clk); chk("R7 level", int'(sample_out), lv[k]);
            end
        end
        step(); level = 3'd1;
        // R5: chain vs single
        play_bank = 1; for (int a = 0; a < 8; a++) wr(3'(a), 16'h1111);
        play_bank = 0; for (int a = 0; a < 8; a++) wr(3'(a), 16'h2222);
        chain_mode = 1; freq = 11'd2047; trigger = 1; @(posedge clk); #1 trigger = 0;
        for (int k = 0; k < 66; k++) begin
            @(negedge clk); chk("R5 chained", int'(sample_out), (k % 64) < 32 ? 1 : 2);
        end
        step(); chain_mode = 0; trigger = 1; @(posedge clk); #1 trigger = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); chk("R5 single", int'(sample_out), 1);
        end
        // R4: period 3 cycles
        step(); freq = 11'd2045; trigger = 1; @(posedge clk); #1 trigger = 0;
        for (int k = 0; k < 9; k++) @(negedge clk);
        // R9: timed length
        step(); timed = 1; len_val = 8'd3; trig();
        tick(); tick();
        @(negedge clk); chk("R9 before expiry", int'(active), 1);
        step(); tick();
        @(negedge clk); chk("R9 expired", int'(active), 0);
        step(); timed = 0; trig(); tick(); tick(); tick(); tick();
        @(negedge clk); chk("R9 untimed ignores ticks", int'(active), 1);
        // R8: disable and blocked trigger
        step(); out_en = 0; step();
        @(negedge clk); chk("R8 disable", int'(active), 0);
        chk("R8 silent", int'(sample_out), 0);
        step(); trig();
        @(negedge clk); chk("R8 blocked trigger", int'(active), 0);
        // Random phase (R10 retriggers included)
        step(); out_en = 1;
        for (int n = 0; n < 4000; n++) begin
            wr_en      = ($urandom % 4) == 0;
            wr_addr    = 3'($urandom);
            wr_data    = 16'($urandom);
            chain_mode = ($urandom % 64) == 0 ? ~chain_mode : chain_mode;
            play_bank  = ($urandom % 48) == 0 ? ~play_bank : play_bank;
            out_en     = ($urandom % 50) != 0;
            freq       = 11'(2040 + ($urandom % 8));
            len_val    = 8'($urandom % 12);
            timed      = ($urandom % 3) == 0;
            level      = 3'($urandom);
            trigger    = ($urandom % 30) == 0;
            len_tick   = ($urandom % 5) == 0;
            step();
        end
        wr_en = 0; trigger = 0; len_tick = 0;
        step();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule